// File: doc/BRIEF.md
# SDRAM Mode Register Load Unit

This block sits between a memory controller's command front end and the rest of the controller. It watches for mode-register-set commands aimed at the base mode register, which is the one selected when both bank-select bits are zero. It checks that each such load is legal before applying it. A legal load updates the stored settings: burst length, burst ordering and read latency. The stored values are then offered as decoded outputs that the read and write schedulers can use directly.

A load is legal only when three conditions hold. Every bank is precharged, no burst is running, and none of the field codes is reserved. A rejected load changes nothing and raises a one-cycle error pulse. Each accepted load is followed by a fixed hold-off interval. During it the ready output stays low, and any command issued then is flagged and dropped.

A load may select the DLL-reset operating mode. Its reset request then appears as a single-cycle pulse that clears itself. An advisory flag also stays raised until a later load in normal mode is accepted.

Top module: `sdram_mode_loader`

## Requirements
- R1: Only a command with cmd_valid=1, cmd_mrs=1 and cmd_ba all zero is treated as a load. Any other command while ready is high leaves the configuration unchanged and gives load_err=0.
- R2: On an accepted load, address bits [2:0] set cfg_burst_len (001 gives 2, 010 gives 4, 011 gives 8) and bit 3 sets cfg_interleave (0 sequential, 1 interleaved). Bits [6:4] set cfg_cl_half (010 gives 0, meaning 2 cycles; 110 gives 1, meaning 2.5 cycles). The new values are visible the cycle after the command.
- R3: A load whose burst-length code is 000 or 1xx is rejected. load_err is high for exactly one cycle and the configuration is unchanged.
- R4: A load whose latency code is anything other than 010 or 110 is rejected in the same way.
- R5: The operating-mode field is address bits [ADDR_W-1:7]. All zeros means normal mode. Only bit 8 set means DLL reset. Any other value rejects the load.
- R6: A load issued while any bank_open bit is set, or while burst_active is high, is rejected. load_err pulses and the configuration is unchanged.
- R7: After an accepted load, ready is low for exactly WAIT_CYCLES cycles (default 2), starting the cycle after the command. A rejected load leaves ready high.
- R8: Any command with cmd_valid=1 issued while ready is low is dropped and gives load_err=1 in the next cycle.
- R9: An accepted DLL-reset load applies its fields and drives dll_reset_pulse high for exactly one cycle.
- R10: relock_advised is set by an accepted DLL-reset load. It is cleared only by an accepted normal-mode load.
- R11: After reset the outputs are cfg_burst_len=2, cfg_interleave=0, cfg_cl_half=0, ready=1, load_err=0, dll_reset_pulse=0 and relock_advised=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_mrs | input | 1 | The command is a mode-register set |
| cmd_ba | input | BANK_W | Bank-select bits of the command |
| cmd_addr | input | ADDR_W | Address bits carrying the mode fields |
| bank_open | input | NUM_BANKS | One bit per bank, high while that bank is active |
| burst_active | input | 1 | High while a read or write burst is in flight |
| ready | output | 1 | Low during the post-load hold-off |
| load_err | output | 1 | One-cycle pulse for a rejected or mistimed command |
| cfg_burst_len | output | 4 | Burst length in beats (2, 4 or 8) |
| cfg_interleave | output | 1 | 1 selects interleaved burst ordering |
| cfg_cl_half | output | 1 | 1 selects read latency 2.5, 0 selects 2 |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| relock_advised | output | 1 | A normal-mode load is recommended |

## Verification
Some rules are checked by assertions on every cycle:
- the hold-off starts after each accepted load;
- a command issued during the hold-off is flagged;
- the DLL pulse lasts one cycle and raises the advisory flag;
- the burst length is always 2, 4 or 8;
- the configuration changes only after a cycle with all banks idle and no burst running;
- an error pulse leaves the configuration untouched.

Other behaviours can only be shown by the bench's directed scenarios:
- the exact field-to-output decoding;
- rejection of each reserved code;
- the exact length of the hold-off;
- that bank-select values other than zero are ignored;
- the advisory flag clearing only after a normal load.

// File: rtl/sdram_mode_loader.sv
module sdram_mode_loader #(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int NUM_BANKS   = 4,
  parameter int WAIT_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_mrs,
  input  logic [BANK_W-1:0]    cmd_ba,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 burst_active,
  output logic                 ready,
  output logic                 load_err,
  output logic [3:0]           cfg_burst_len,
  output logic                 cfg_interleave,
  output logic                 cfg_cl_half,
  output logic                 dll_reset_pulse,
  output logic                 relock_advised
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1) > 0 ? $clog2(WAIT_CYCLES + 1) : 1;
  localparam int OP_W  = ADDR_W - 7;

  logic [CNT_W-1:0] wait_cnt;
  logic [OP_W-1:0]  op_field;
  logic bl_ok, cl_ok, op_norm, op_dll, is_load, accept, reject;

  assign op_field = cmd_addr[ADDR_W-1:7];
  assign bl_ok    = (cmd_addr[2:0] == 3'b001) || (cmd_addr[2:0] == 3'b010) ||
                    (cmd_addr[2:0] == 3'b011);
  assign cl_ok    = (cmd_addr[6:4] == 3'b010) || (cmd_addr[6:4] == 3'b110);
  assign op_norm  = (op_field == '0);
  assign op_dll   = (op_field == OP_W'(2));
  assign is_load  = cmd_valid && cmd_mrs && (cmd_ba == '0);
  assign ready    = (wait_cnt == '0);
  assign accept   = ready && is_load && bl_ok && cl_ok && (op_norm || op_dll) &&
                    (bank_open == '0) && !burst_active;
  assign reject   = (cmd_valid && !ready) || (ready && is_load && !accept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt        <= '0;
      load_err        <= 1'b0;
      cfg_burst_len   <= 4'd2;
      cfg_interleave  <= 1'b0;
      cfg_cl_half     <= 1'b0;
      dll_reset_pulse <= 1'b0;
      relock_advised  <= 1'b0;
    end else begin
      load_err        <= reject;
      dll_reset_pulse <= accept && op_dll;
      if (accept) begin
        wait_cnt       <= CNT_W'(WAIT_CYCLES);
        cfg_burst_len  <= 4'd1 << cmd_addr[1:0];
        cfg_interleave <= cmd_addr[3];
        cfg_cl_half    <= cmd_addr[6];
        relock_advised <= op_dll;
      end else if (!ready) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  p_wait_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  p_cmd_in_wait_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> load_err);

  p_dll_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |=> !dll_reset_pulse);

  p_dll_sets_advice_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |-> relock_advised);

  p_bl_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_burst_len == 4'd2) || (cfg_burst_len == 4'd4) || (cfg_burst_len == 4'd8));

  p_change_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_burst_len != $past(cfg_burst_len)) || (cfg_interleave != $past(cfg_interleave)) ||
     (cfg_cl_half != $past(cfg_cl_half)))
    |-> (($past(bank_open) == '0) && !$past(burst_active)));

  p_err_keeps_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> ((cfg_burst_len == $past(cfg_burst_len)) &&
                  (cfg_interleave == $past(cfg_interleave)) &&
                  (cfg_cl_half == $past(cfg_cl_half))));

endmodule

// File: tb/sdram_mode_loader_test.sv
`timescale 1ns/1ps
module sdram_mode_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_mrs = 1'b0, burst_active = 1'b0;
  logic [1:0]  cmd_ba = '0;
  logic [12:0] cmd_addr = '0;
  logic [3:0]  bank_open = '0;
  logic        ready, load_err, cfg_interleave, cfg_cl_half, dll_reset_pulse, relock_advised;
  logic [3:0]  cfg_burst_len;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sdram_mode_loader uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mrs(cmd_mrs), .cmd_ba(cmd_ba),
    .cmd_addr(cmd_addr), .bank_open(bank_open), .burst_active(burst_active),
    .ready(ready), .load_err(load_err), .cfg_burst_len(cfg_burst_len),
    .cfg_interleave(cfg_interleave), .cfg_cl_half(cfg_cl_half),
    .dll_reset_pulse(dll_reset_pulse), .relock_advised(relock_advised));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic mrs, input logic [1:0] ba, input logic [12:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mrs = mrs; cmd_ba = ba; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_mrs = 1'b0; cmd_ba = '0; cmd_addr = '0;
  endtask

  task automatic cfg_is(input string req, input int bl, input int il, input int half);
    check(req, cfg_burst_len, bl);
    check(req, cfg_interleave, il);
    check(req, cfg_cl_half, half);
  endtask

  task automatic drain();
    while (!ready) @(negedge clk);
  endtask

  task automatic t_reset_r11();
    cfg_is("R11", 2, 0, 0);
    check("R11 ready", ready, 1);
    check("R11 err", load_err, 0);
    check("R11 dll", dll_reset_pulse, 0);
    check("R11 advised", relock_advised, 0);
  endtask

  task automatic t_decode_r2_r7();
    issue(1'b1, 2'd0, 13'h06B);
    cfg_is("R2 bl8 il cl2.5", 8, 1, 1);
    check("R2 err", load_err, 0);
    check("R7 ready low 1", ready, 0);
    @(negedge clk); check("R7 ready low 2", ready, 0);
    @(negedge clk); check("R7 ready back", ready, 1);
    issue(1'b1, 2'd0, 13'h022);
    cfg_is("R2 bl4 seq cl2", 4, 0, 0);
    drain();
    issue(1'b1, 2'd0, 13'h029);
    cfg_is("R2 bl2 il cl2", 2, 1, 0);
    drain();
  endtask

  task automatic t_ignored_r1();
    issue(1'b1, 2'd1, 13'h06B);
    cfg_is("R1 ba!=0", 2, 1, 0);
    check("R1 ba!=0 err", load_err, 0);
    check("R1 ba!=0 ready", ready, 1);
    issue(1'b0, 2'd0, 13'h06B);
    cfg_is("R1 non-mrs", 2, 1, 0);
    check("R1 non-mrs err", load_err, 0);
  endtask

  task automatic t_reserved_r3_r4_r5();
    issue(1'b1, 2'd0, 13'h024);
    check("R3 err", load_err, 1);
    cfg_is("R3 cfg kept", 2, 1, 0);
    check("R7 no wait after reject", ready, 1);
    @(negedge clk); check("R3 err one cycle", load_err, 0);
    issue(1'b1, 2'd0, 13'h020);
    check("R3 code000 err", load_err, 1);
    issue(1'b1, 2'd0, 13'h031);
    check("R4 err", load_err, 1);
    cfg_is("R4 cfg kept", 2, 1, 0);
    issue(1'b1, 2'd0, 13'h0A3);
    check("R5 bit7 err", load_err, 1);
    issue(1'b1, 2'd0, 13'h323);
    check("R5 bit8+9 err", load_err, 1);
    cfg_is("R5 cfg kept", 2, 1, 0);
  endtask

  task automatic t_busy_r6();
    bank_open = 4'b0100;
    issue(1'b1, 2'd0, 13'h06B);
    check("R6 bank err", load_err, 1);
    cfg_is("R6 bank cfg kept", 2, 1, 0);
    bank_open = '0; burst_active = 1'b1;
    issue(1'b1, 2'd0, 13'h06B);
    check("R6 burst err", load_err, 1);
    cfg_is("R6 burst cfg kept", 2, 1, 0);
    burst_active = 1'b0;
  endtask

  task automatic t_wait_cmd_r8();
    issue(1'b1, 2'd0, 13'h022);
    issue(1'b1, 2'd0, 13'h06B);
    check("R8 err", load_err, 1);
    cfg_is("R8 dropped", 4, 0, 0);
    drain();
  endtask

  task automatic t_dll_r9_r10();
    issue(1'b1, 2'd0, 13'h16B);
    check("R9 pulse", dll_reset_pulse, 1);
    cfg_is("R9 fields applied", 8, 1, 1);
    check("R10 set", relock_advised, 1);
    @(negedge clk); check("R9 pulse clears", dll_reset_pulse, 0);
    drain();
    issue(1'b1, 2'd0, 13'h024);
    check("R10 kept on reject", relock_advised, 1);
    issue(1'b1, 2'd0, 13'h022);
    check("R10 cleared", relock_advised, 0);
    check("R9 no pulse normal", dll_reset_pulse, 0);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r11();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r11();
    t_decode_r2_r7();
    t_ignored_r1();
    t_reserved_r3_r4_r5();
    t_busy_r6();
    t_wait_cmd_r8();
    t_dll_r9_r10();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule